// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into an asynchronous serial bit stream on a single output line. An 8-bit framing control word sets the number of data bits (5 to 8) and the parity mode (none, odd, even, forced mark or forced space). It also sets the stop length (one, one and a half or two bits) and a break that holds the line low. An external baud enable pulses once per oversample period. Each bit lasts `OSR` pulses, and a half stop bit lasts `OSR/2` pulses.

Bytes enter through a one-word holding register with a valid/ready handshake. A character can wait there while the previous one is still shifting out. A clear-to-send gate can be enabled so that a new character waits for `cts`. A character that has already started always runs to its end. Two status outputs report whether the holding register has room and whether the whole transmitter is idle.

The sequencer uses five states. From IDLE it goes to START when the holding register is full and the gate is open; this is the load transition. START always goes to DATA. DATA goes to PARITY after the last data bit when parity is enabled, and to STOP when it is not. PARITY goes to STOP, and STOP goes back to IDLE. Every move out of START, DATA, PARITY or STOP happens on the baud pulse that completes the bit period.

Top module: `async_tx`

## Requirements
- R1: After reset, and whenever nothing is queued or shifting and break is off, `txd` is 1 and `hold_empty`, `tx_empty` and `in_ready` are all 1.
- R2: `lcr[1:0]` sets the word length: 00 gives 5 data bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits from above the word length are not sent. `lcr[7]` has no effect on the frame.
- R3: With `lcr[2]`=0 the stop period is one bit (OSR pulses). With `lcr[2]`=1 it is 1.5 bits (OSR+OSR/2 pulses) for 5-bit words and 2 bits (2*OSR pulses) for 6, 7 or 8-bit words.
- R4: With `lcr[3]`=1 and `lcr[5]`=0, one parity bit follows the last data bit. It makes the count of ones in the data bits plus the parity bit even when `lcr[4]`=1, and odd when `lcr[4]`=0. With `lcr[3]`=0 no parity bit is sent.
- R5: With `lcr[3]`=1 and `lcr[5]`=1 the parity bit is constant: 1 when `lcr[4]`=0 (value 0x28 in the parity field) and 0 when `lcr[4]`=1 (0x38).
- R6: While `lcr[6]`=1, `txd` is 0, including in the middle of a character. The character keeps its timing underneath, and the transmitter returns to idle when that character ends.
- R7: `in_ready` equals `hold_empty`. A byte taken with `in_valid` and `in_ready` makes `hold_empty` 0 on the next cycle. The holding register becomes empty again when its byte starts shifting, so one more byte can be queued during a character.
- R8: `tx_empty` is 1 only when the holding register is empty and no character is being shifted.
- R9: With `cts_en`=1 and `cts`=0, a queued byte does not start, and a character already in progress completes. With `cts_en`=0, `cts` has no effect.
- R10: A frame is one start bit at 0, then the data bits LSB first, then the optional parity bit, then the stop bits at 1. Each bit lasts OSR baud pulses. State changes happen only on baud pulses, except for the load from IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Baud enable, one pulse per oversample period |
| lcr | input | 8 | Framing control word |
| cts_en | input | 1 | Enables the clear-to-send gate |
| cts | input | 1 | Clear to send, 1 = clear |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Holding register can accept a byte |
| txd | output | 1 | Serial line output, idle 1 |
| hold_empty | output | 1 | Holding register is empty |
| tx_empty | output | 1 | Holding register and shifter are both idle |

## Verification
Random bytes are sent with random framing words, including random `lcr[7]`. The baud pulse runs either every cycle or on a sparse random pattern. Each line sample taken on a baud pulse is compared with a model of the frame, so an error in data order, masking, parity polarity or segment length shows up as a mismatched sample. Directed frames cover each parity mode with data that makes the even and odd results differ, and a 5-bit word whose upper bits are set to show the masking. Two back-to-back characters measure the stop length, which a single frame cannot show. Separate sequences hold the clear-to-send gate closed before a character and during one, and raise break both at idle and in the middle of a run of ones.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;

    typedef struct packed {
        logic       brk;
        logic       stick;
        logic       even;
        logic       pen;
        logic       stb;
        logic [1:0] wlen;
    } frame_cfg_t;

    function automatic frame_cfg_t decode_cfg(input logic [7:0] word);
        frame_cfg_t c;
        c.wlen  = word[1:0];
        c.stb   = word[2];
        c.pen   = word[3];
        c.even  = word[4];
        c.stick = word[5];
        c.brk   = word[6];
        return c;
    endfunction

endpackage

// File: rtl/async_tx_hold.sv
module async_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full   <= 1'b0;
            data_o <= '0;
        end else if (!full && in_valid) begin
            full   <= 1'b1;
            data_o <= in_data;
        end else if (full && take) begin
            full   <= 1'b0;
        end
    end

    assign in_ready = !full;

endmodule

// File: rtl/async_tx_par.sv
module async_tx_par #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        wlen,
    input  logic              even,
    input  logic              stick,
    output logic              par_bit
);

    localparam int MIN_W = DATA_W - 3;

    logic [DATA_W-1:0] keep;

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_mask
            if (i < MIN_W) begin : g_always
                assign keep[i] = data[i];
            end else begin : g_sel
                assign keep[i] = data[i] & (int'(wlen) >= (i - MIN_W + 1));
            end
        end
    endgenerate

    logic ones_odd;
    assign ones_odd = ^keep;

    always_comb begin
        if (stick) begin
            par_bit = !even;
        end else if (even) begin
            par_bit = ones_odd;
        end else begin
            par_bit = !ones_odd;
        end
    end

endmodule

// File: rtl/async_tx_fsm.sv
module async_tx_fsm
    import async_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start_ok,
    input  logic [DATA_W-1:0] data,
    input  frame_cfg_t        cfg,
    input  logic              par_bit,
    output logic              take,
    output logic              busy,
    output logic              line
);

    localparam int MIN_W = DATA_W - 3;
    localparam int CW    = $clog2(2 * OSR);
    localparam int BW    = $clog2(DATA_W);
    localparam logic [CW-1:0] LIM_ONE  = CW'(OSR - 1);
    localparam logic [CW-1:0] LIM_HALF = CW'(OSR + OSR / 2 - 1);
    localparam logic [CW-1:0] LIM_TWO  = CW'(2 * OSR - 1);

    tx_state_t         state, nxt;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     stop_lim;
    logic [BW-1:0]     bitidx;
    logic [BW-1:0]     nlast;
    logic [DATA_W-1:0] shreg;
    logic              par_q;
    logic              pen_q;
    logic              seg_end;
    logic              load;

    assign load    = (state == ST_IDLE) && start_ok;
    assign seg_end = tick && (cnt == ((state == ST_STOP) ? stop_lim : LIM_ONE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start_ok) nxt = ST_START;
            ST_START:  if (seg_end) nxt = ST_DATA;
            ST_DATA:   if (seg_end && bitidx == nlast) nxt = pen_q ? ST_PARITY : ST_STOP;
            ST_PARITY: if (seg_end) nxt = ST_STOP;
            ST_STOP:   if (seg_end) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            stop_lim <= LIM_ONE;
            bitidx   <= '0;
            nlast    <= '0;
            shreg    <= '0;
            par_q    <= 1'b1;
            pen_q    <= 1'b0;
        end else begin
            if (state == ST_IDLE || seg_end) begin
                cnt <= '0;
            end else if (tick) begin
                cnt <= cnt + 1'b1;
            end
            if (load) begin
                shreg  <= data;
                par_q  <= par_bit;
                pen_q  <= cfg.pen;
                bitidx <= '0;
                nlast  <= BW'(MIN_W - 1) + BW'(cfg.wlen);
                if (!cfg.stb) begin
                    stop_lim <= LIM_ONE;
                end else if (cfg.wlen == 2'b00) begin
                    stop_lim <= LIM_HALF;
                end else begin
                    stop_lim <= LIM_TWO;
                end
            end else if (state == ST_DATA && seg_end) begin
                shreg  <= shreg >> 1;
                bitidx <= bitidx + 1'b1;
            end
        end
    end

    always_comb begin
        take = load;
        busy = (state != ST_IDLE);
        unique case (state)
            ST_IDLE:   line = 1'b1;
            ST_START:  line = 1'b0;
            ST_DATA:   line = shreg[0];
            ST_PARITY: line = par_q;
            ST_STOP:   line = 1'b1;
            default:   line = 1'b1;
        endcase
    end

endmodule

// File: rtl/async_tx.sv
module async_tx
    import async_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [7:0]        lcr,
    input  logic              cts_en,
    input  logic              cts,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_empty
);

    frame_cfg_t        cfg;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              busy;
    logic              line;
    logic              par_bit;
    logic              start_ok;
    logic              unused_lcr7;

    assign cfg         = decode_cfg(lcr);
    assign unused_lcr7 = lcr[7];
    assign start_ok    = hold_full && (!cts_en || cts);

    async_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .take     (take),
        .full     (hold_full),
        .data_o   (hold_data)
    );

    async_tx_par #(.DATA_W(DATA_W)) u_par (
        .data    (hold_data),
        .wlen    (cfg.wlen),
        .even    (cfg.even),
        .stick   (cfg.stick),
        .par_bit (par_bit)
    );

    async_tx_fsm #(.DATA_W(DATA_W), .OSR(OSR)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start_ok (start_ok),
        .data     (hold_data),
        .cfg      (cfg),
        .par_bit  (par_bit),
        .take     (take),
        .busy     (busy),
        .line     (line)
    );

    assign txd        = cfg.brk ? 1'b0 : line;
    assign hold_empty = !hold_full;
    assign tx_empty   = !busy && !hold_full;

endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] lcr,
    input logic       cts_en,
    input logic       cts,
    input logic       in_valid,
    input logic       in_ready,
    input logic       txd,
    input logic       hold_empty,
    input logic       tx_empty,
    input logic       busy
);

    p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !lcr[6]) |-> txd);

    p_break_space_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lcr[6] |-> !txd);

    p_accept_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !hold_empty);

    p_start_from_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!hold_empty));

    p_empty_needs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> hold_empty);

    p_cts_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cts_en && !cts) |=> !busy);

endmodule

bind async_tx async_tx_chk u_chk (.*);

// File: tb/async_tx_test.sv
module async_tx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic [7:0] lcr = 8'h03;
    logic       cts_en = 1'b0;
    logic       cts = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready, txd, hold_empty, tx_empty;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit tick_rand = 1'b0;

    always #10 clk = ~clk;

    async_tx uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .lcr(lcr), .cts_en(cts_en), .cts(cts),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready), .txd(txd),
        .hold_empty(hold_empty), .tx_empty(tx_empty)
    );

    always @(posedge clk) begin
        #2;
        tick = tick_rand ? (($urandom % 3) == 0) : 1'b1;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog actual=%0d expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nbits(input logic [7:0] l);
        return 5 + int'(l[1:0]);
    endfunction

    function automatic int flen(input logic [7:0] l);
        int s;
        s = l[2] ? ((nbits(l) == 5) ? 24 : 32) : 16;
        return 16 * (1 + nbits(l)) + (l[3] ? 16 : 0) + s;
    endfunction

    function automatic bit pbit(input logic [7:0] d, input logic [7:0] l);
        bit x = 1'b0;
        for (int k = 0; k < nbits(l); k++) x ^= d[k];
        if (l[5]) return !l[4];
        return l[4] ? x : !x;
    endfunction

    function automatic bit ebit(input logic [7:0] d, input logic [7:0] l, input int i);
        int j = i;
        if (j < 16) return 1'b0;
        j -= 16;
        if (j < nbits(l) * 16) return d[j / 16];
        j -= nbits(l) * 16;
        if (l[3]) begin
            if (j < 16) return pbit(d, l);
        end
        return 1'b1;
    endfunction

    task automatic setl(input logic [7:0] v);
        @(posedge clk); #2;
        lcr = v;
    endtask

    task automatic push(input logic [7:0] d);
        @(posedge clk); #2;
        in_data  = d;
        in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #2;
        in_valid = 1'b0;
    endtask

    task automatic expect_frame(input logic [7:0] d, input logic [7:0] l, input string req);
        int waitc = 0;
        int miss = 0;
        while (1) begin
            @(negedge clk);
            if (tick && txd == 1'b0) break;
            waitc++;
            if (waitc > 20000) begin
                chk(1'b0, req, waitc, 0);
                return;
            end
        end
        for (int idx = 0; idx < flen(l); idx++) begin
            if (idx > 0) begin
                do @(negedge clk); while (!tick);
            end
            if (txd != ebit(d, l, idx)) miss++;
        end
        chk(miss == 0, req, miss, 0);
    endtask

    task automatic stop_gap(input logic [7:0] l, input string req);
        int n = 0;
        bit prev = 1'b0;
        tick_rand = 1'b0;
        setl(l);
        fork
            begin
                push(8'hFF);
                push(8'hFF);
                @(negedge clk);
                chk(hold_empty == 1'b0 && in_ready == 1'b0, "R7 second byte queued", hold_empty, 0);
            end
            begin
                do @(negedge clk); while (txd != 1'b0);
                while (1) begin
                    @(negedge clk);
                    n++;
                    if (prev && txd == 1'b0) break;
                    prev = txd;
                    if (n > 2000) break;
                end
            end
        join
        chk(n == flen(l) + 1, req, n, flen(l) + 1);
        while (!tx_empty) @(negedge clk);
    endtask

    initial begin
        logic [7:0] d, l;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(txd && hold_empty && tx_empty && in_ready, "R1 reset state",
            {txd, hold_empty, tx_empty, in_ready}, 15);

        // directed parity and word length
        setl(8'h1B); push(8'h01); expect_frame(8'h01, 8'h1B, "R4 even parity");
        setl(8'h0B); push(8'h01); expect_frame(8'h01, 8'h0B, "R4 odd parity");
        setl(8'h18); push(8'hE1); expect_frame(8'hE1, 8'h18, "R2 R4 5-bit mask");
        setl(8'h2B); push(8'h00); expect_frame(8'h00, 8'h2B, "R5 stick mark");
        setl(8'h3B); push(8'hFF); expect_frame(8'hFF, 8'h3B, "R5 stick space");
        setl(8'h82); push(8'hA5); expect_frame(8'hA5, 8'h82, "R2 7-bit lcr7 ignored");

        // stop lengths with back-to-back characters
        stop_gap(8'h04, "R3 1.5 stop 5-bit");
        stop_gap(8'h07, "R3 2 stop 8-bit");
        stop_gap(8'h01, "R3 1 stop 6-bit");

        // random frames
        for (int k = 0; k < 30; k++) begin
            l = 8'($urandom) & 8'hBF;
            d = 8'($urandom);
            tick_rand = (k % 2) == 1;
            setl(l);
            push(d);
            expect_frame(d, l, "R2 R3 R4 R5 R10 random");
        end
        tick_rand = 1'b0;
        while (!tx_empty) @(negedge clk);
        @(negedge clk);
        chk(tx_empty && txd, "R8 idle after frames", {tx_empty, txd}, 3);

        // clear-to-send gate
        setl(8'h03);
        cts_en = 1'b1;
        cts    = 1'b0;
        push(8'h5A);
        repeat (50) @(negedge clk);
        chk(txd && !hold_empty && !tx_empty && !in_ready, "R9 gate holds queued byte",
            {txd, hold_empty, tx_empty, in_ready}, 8);
        @(posedge clk); #2 cts = 1'b1;
        fork
            expect_frame(8'h5A, 8'h03, "R9 started char completes");
            begin
                repeat (20) @(negedge clk);
                chk(hold_empty && !tx_empty, "R7 R8 hold free while shifting",
                    {hold_empty, tx_empty}, 2);
                push(8'h3C);
                @(posedge clk); #2 cts = 1'b0;
            end
        join
        repeat (200) @(negedge clk);
        chk(txd && !hold_empty && !tx_empty, "R9 second byte blocked",
            {txd, hold_empty, tx_empty}, 4);
        @(posedge clk); #2 cts_en = 1'b0;
        expect_frame(8'h3C, 8'h03, "R9 gate disabled ignores cts");
        while (!tx_empty) @(negedge clk);
        chk(tx_empty && hold_empty, "R8 empty after drain", {tx_empty, hold_empty}, 3);

        // break
        setl(8'h40);
        @(negedge clk);
        chk(txd == 1'b0, "R6 break at idle", txd, 0);
        setl(8'h03);
        @(negedge clk);
        chk(txd == 1'b1, "R1 line idle after break", txd, 1);
        push(8'hFF);
        repeat (40) @(negedge clk);
        chk(txd == 1'b1, "R10 mid-data level", txd, 1);
        setl(8'h43);
        begin
            int hi = 0;
            repeat (30) begin
                @(negedge clk);
                if (txd) hi++;
            end
            chk(hi == 0, "R6 break overrides character", hi, 0);
        end
        setl(8'h03);
        begin
            int w = 0;
            while (!tx_empty && w < 1000) begin
                @(negedge clk);
                w++;
            end
            chk(w < 200 && txd, "R6 character ends after break", w, 150);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule